// File: doc/BRIEF.md
# I/O MMU Register Bank

This block is the word-addressed register bank of an I/O memory management unit. A simple bus slave port selects one 32-bit register by its word index, which is the byte address minus the block's base address, divided by four. The registers are spread over three 4 KB pages. The first page holds the control register, the page-table base register and two write-only flush triggers. The second page holds the async and memory fault status and address registers and one configuration register per bus slot. The third page holds the module-id register.

A write to the control register also decodes the 3-bit mapping-range code in that write into the start address of the device virtual address window. The window start, the page-table base and the enable bit are driven straight out to a translation engine. The fault, slot configuration and module-id registers are plain storage. A flush write produces only a one-cycle pulse, and a page flush carries its written word with it. Reads are combinational from the stored state.

Top module: `iommu_regbank`

## Requirements
- R1: After reset every register reads 0, except module-id, which reads 0x00000008. The window start output is 0xFF000000, the enable and table-base outputs are 0, and both flush pulses are low.
- R2: The word index is (bus_addr - BASE_ADDR) >> 2. The storage words are 0 (control), 1 (table base), 1024 and 1025 (async status and address), 1028 to 1031 (slot 0 to 3 configuration), 1032 and 1033 (memory status and address), and 2048 (module-id). A write stores all 32 bits, and a read in any later cycle returns them.
- R3: A write to word 0 whose bits [4:2] hold code k sets the window start output to 0xFFFFFFFF << (24+k). This gives 0xFF000000 for k=0 and 0x80000000 for k=7. The new value is visible right after the clock edge that takes the write.
- R4: The enable output equals bit 0 of the stored control word, and the table-base output equals the stored word 1. Control bits [31:24] (implementation and version) are stored and read back as written.
- R5: The window start changes only on a write to word 0. Writes to any other word leave it unchanged.
- R6: Module-id bits [3:0] always read 0x8. Bits [31:4] store what is written.
- R7: A write to word 5 raises tlb_flush_pulse for exactly the one cycle after the write edge. A write to word 6 does the same on page_flush_pulse, and page_flush_addr then holds the written word.
- R8: Reads of words 5 and 6 and of every unmapped word return 0.
- R9: Writes to unmapped words, including addresses below the base or beyond the third page, change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| xlat_win_start | output | 32 | Start address of the translation window |
| xlat_tbl_base | output | 32 | Page-table base register value |
| xlat_enable | output | 1 | Translation enable (control bit 0) |
| tlb_flush_pulse | output | 1 | One-cycle pulse after a write to word 5 |
| page_flush_pulse | output | 1 | One-cycle pulse after a write to word 6 |
| page_flush_addr | output | 32 | Word written by the last page-flush write |

## Verification
The range decode is driven with all eight codes, and each code is combined with different implementation, version and enable bits. This separates a wrong shift amount from leakage of the upper control bits into the window. Every storage word is written with a distinct pattern derived from its index, so swapped offsets or shared storage show up on read-back. A write is then made to every unmapped word in the three pages and to addresses outside the block, followed by a read sweep over every word. This separates a decode that aliases a neighbouring offset from one that only ignores far-away addresses. The flush words are written back to back with other words, which confirms that each pulse lasts a single cycle and that the page-flush data is captured.

// File: rtl/iommu_regbank_pkg.sv
package iommu_regbank_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned SLOT_CNT   = 4;
    localparam int unsigned PAGE_WORDS = 1024;
    localparam int unsigned CODE_W     = 3;
    localparam int unsigned CODE_LSB   = 2;
    localparam int unsigned WIN_SHIFT0 = 24;

    localparam int unsigned W_CTRL  = 0;
    localparam int unsigned W_TBL   = 1;
    localparam int unsigned W_TLBF  = 5;
    localparam int unsigned W_PGF   = 6;
    localparam int unsigned W_AFSR  = PAGE_WORDS;
    localparam int unsigned W_AFAR  = PAGE_WORDS + 1;
    localparam int unsigned W_CFG0  = PAGE_WORDS + 4;
    localparam int unsigned W_MFSR  = W_CFG0 + SLOT_CNT;
    localparam int unsigned W_MFAR  = W_MFSR + 1;
    localparam int unsigned W_MID   = 2 * PAGE_WORDS;

    localparam logic [3:0] MID_FIXED = 4'h8;

    typedef struct packed {
        logic                ctrl;
        logic                tbl;
        logic                afsr;
        logic                afar;
        logic [SLOT_CNT-1:0] cfg;
        logic                mfsr;
        logic                mfar;
        logic                mid;
        logic                tlbf;
        logic                pgf;
    } sel_t;

    typedef struct packed {
        logic [DATA_W-1:0]               ctrl;
        logic [DATA_W-1:0]               tbl;
        logic [DATA_W-1:0]               afsr;
        logic [DATA_W-1:0]               afar;
        logic [SLOT_CNT-1:0][DATA_W-1:0] cfg;
        logic [DATA_W-1:0]               mfsr;
        logic [DATA_W-1:0]               mfar;
        logic [DATA_W-1:0]               mid;
        logic [DATA_W-1:0]               win;
        logic [DATA_W-1:0]               pgf_data;
        logic                            tlb_p;
        logic                            pgf_p;
    } state_t;

endpackage

// File: rtl/iommu_word_decode.sv
module iommu_word_decode
    import iommu_regbank_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter int unsigned ADDR_W    = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    logic [ADDR_W-1:0]   woff;
    logic [SLOT_CNT-1:0] cfg_hit;

    assign woff = (addr - ADDR_W'(BASE_ADDR)) >> 2;

    for (genvar s = 0; s < SLOT_CNT; s++) begin : g_cfg
        assign cfg_hit[s] = (woff == ADDR_W'(W_CFG0 + s));
    end

    always_comb begin
        sel      = '0;
        sel.ctrl = (woff == ADDR_W'(W_CTRL));
        sel.tbl  = (woff == ADDR_W'(W_TBL));
        sel.afsr = (woff == ADDR_W'(W_AFSR));
        sel.afar = (woff == ADDR_W'(W_AFAR));
        sel.cfg  = cfg_hit;
        sel.mfsr = (woff == ADDR_W'(W_MFSR));
        sel.mfar = (woff == ADDR_W'(W_MFAR));
        sel.mid  = (woff == ADDR_W'(W_MID));
        sel.tlbf = (woff == ADDR_W'(W_TLBF));
        sel.pgf  = (woff == ADDR_W'(W_PGF));
    end
endmodule

// File: rtl/iommu_window_decode.sv
module iommu_window_decode
    import iommu_regbank_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] start
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    always_comb begin
        start = ALL_ONES << (WIN_SHIFT0 + 32'(code));
    end
endmodule

// File: rtl/iommu_regbank.sv
module iommu_regbank
    import iommu_regbank_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter int unsigned ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] xlat_win_start,
    output logic [DATA_W-1:0] xlat_tbl_base,
    output logic              xlat_enable,
    output logic              tlb_flush_pulse,
    output logic              page_flush_pulse,
    output logic [DATA_W-1:0] page_flush_addr
);
    localparam logic [DATA_W-1:0] WIN_RESET = {{(DATA_W-WIN_SHIFT0){1'b1}}, {WIN_SHIFT0{1'b0}}};

    sel_t              sel;
    state_t            st_d, st_q;
    logic [DATA_W-1:0] win_dec;

    iommu_word_decode #(
        .BASE_ADDR (BASE_ADDR),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    iommu_window_decode u_win (
        .code  (bus_wdata[CODE_LSB +: CODE_W]),
        .start (win_dec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.tlb_p = 1'b0;
        st_d.pgf_p = 1'b0;
        if (bus_wr) begin
            if (sel.ctrl) begin
                st_d.ctrl = bus_wdata;
                st_d.win  = win_dec;
            end
            if (sel.tbl)  st_d.tbl  = bus_wdata;
            if (sel.afsr) st_d.afsr = bus_wdata;
            if (sel.afar) st_d.afar = bus_wdata;
            for (int s = 0; s < SLOT_CNT; s++) begin
                if (sel.cfg[s]) st_d.cfg[s] = bus_wdata;
            end
            if (sel.mfsr) st_d.mfsr = bus_wdata;
            if (sel.mfar) st_d.mfar = bus_wdata;
            if (sel.mid)  st_d.mid  = {bus_wdata[DATA_W-1:4], MID_FIXED};
            if (sel.tlbf) st_d.tlb_p = 1'b1;
            if (sel.pgf) begin
                st_d.pgf_p    = 1'b1;
                st_d.pgf_data = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.mid <= {{(DATA_W-4){1'b0}}, MID_FIXED};
            st_q.win <= WIN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.ctrl) bus_rdata = st_q.ctrl;
        if (sel.tbl)  bus_rdata = st_q.tbl;
        if (sel.afsr) bus_rdata = st_q.afsr;
        if (sel.afar) bus_rdata = st_q.afar;
        for (int s = 0; s < SLOT_CNT; s++) begin
            if (sel.cfg[s]) bus_rdata = st_q.cfg[s];
        end
        if (sel.mfsr) bus_rdata = st_q.mfsr;
        if (sel.mfar) bus_rdata = st_q.mfar;
        if (sel.mid)  bus_rdata = st_q.mid;
    end

    assign xlat_win_start   = st_q.win;
    assign xlat_tbl_base    = st_q.tbl;
    assign xlat_enable      = st_q.ctrl[0];
    assign tlb_flush_pulse  = st_q.tlb_p;
    assign page_flush_pulse = st_q.pgf_p;
    assign page_flush_addr  = st_q.pgf_data;
endmodule

// File: rtl/iommu_regbank_chk.sv
module iommu_regbank_chk
    import iommu_regbank_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
    parameter int unsigned ADDR_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] xlat_win_start,
    input logic              xlat_enable,
    input logic              tlb_flush_pulse,
    input logic              page_flush_pulse,
    input logic [DATA_W-1:0] page_flush_addr
);
    logic [ADDR_W-1:0] w;
    logic hit_ctrl, hit_tlb, hit_pgf, hit_mid;

    assign w        = (bus_addr - ADDR_W'(BASE_ADDR)) >> 2;
    assign hit_ctrl = (w == ADDR_W'(0));
    assign hit_tlb  = (w == ADDR_W'(5));
    assign hit_pgf  = (w == ADDR_W'(6));
    assign hit_mid  = (w == ADDR_W'(2048));

    a_r3_window_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_win_start[23:0] == 24'h0) && xlat_win_start[31] &&
        ($countones(xlat_win_start) <= 8));

    a_r5_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && hit_ctrl) |=> $stable(xlat_win_start));

    a_r4_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ctrl) |=> (xlat_enable == $past(bus_wdata[0])));

    a_r7_tlb_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_pulse |-> $past(bus_wr && hit_tlb));

    a_r7_page_data: assert property (@(posedge clk) disable iff (!rst_n)
        page_flush_pulse |-> (page_flush_addr == $past(bus_wdata)));

    a_r6_mid_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mid |-> (bus_rdata[3:0] == 4'h8));

    a_r8_flush_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_tlb || hit_pgf) |-> (bus_rdata == '0));
endmodule

bind iommu_regbank iommu_regbank_chk #(
    .BASE_ADDR (BASE_ADDR),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_addr         (bus_addr),
    .bus_wr           (bus_wr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .xlat_win_start   (xlat_win_start),
    .xlat_enable      (xlat_enable),
    .tlb_flush_pulse  (tlb_flush_pulse),
    .page_flush_pulse (page_flush_pulse),
    .page_flush_addr  (page_flush_addr)
);

// File: tb/iommu_regbank_bench.sv
module iommu_regbank_bench;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam int NW = 2051;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, xlat_win_start, xlat_tbl_base, page_flush_addr;
    logic        xlat_enable, tlb_flush_pulse, page_flush_pulse;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [0:NW-1];
    logic [31:0] win_tab [0:7];

    always #5 clk = ~clk;

    iommu_regbank #(.BASE_ADDR(BASE), .ADDR_W(32)) u_iommu_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xlat_win_start(xlat_win_start), .xlat_tbl_base(xlat_tbl_base),
        .xlat_enable(xlat_enable), .tlb_flush_pulse(tlb_flush_pulse),
        .page_flush_pulse(page_flush_pulse), .page_flush_addr(page_flush_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic bit is_store(input int w);
        return (w == 0) || (w == 1) || (w == 1024) || (w == 1025) ||
               (w >= 1028 && w <= 1033) || (w == 2048);
    endfunction

    task automatic wr_addr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_word(input int w, input logic [31:0] d);
        wr_addr(BASE + 32'(w) * 4, d);
        if (w < NW && is_store(w)) model[w] = (w == 2048) ? {d[31:4], 4'h8} : d;
    endtask

    task automatic rd_word(input int w, output logic [31:0] d);
        @(negedge clk);
        bus_addr = BASE + 32'(w) * 4;
        #1 d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rv, win_before, exp;
        bit en_before;
        for (int k = 0; k < 8; k++) win_tab[k] = 32'hFFFF_FFFF << (24 + k);
        for (int w = 0; w < NW; w++) model[w] = '0;
        model[2048] = 32'h8;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check(xlat_win_start == 32'hFF00_0000, "R1 window", xlat_win_start, 32'hFF00_0000);
        check(xlat_enable == 1'b0, "R1 enable", 32'(xlat_enable), 0);
        check(xlat_tbl_base == 0, "R1 table base", xlat_tbl_base, 0);
        check(!tlb_flush_pulse && !page_flush_pulse, "R1 pulses", {tlb_flush_pulse, page_flush_pulse}, 0);
        rd_word(0, rv);    check(rv == 0, "R1 ctrl", rv, 0);
        rd_word(2048, rv); check(rv == 32'h8, "R1 mid", rv, 32'h8);
        rd_word(1030, rv); check(rv == 0, "R1 slot cfg", rv, 0);

        // R3 / R4: every range code with varied upper bits and enable
        for (int k = 0; k < 8; k++) begin
            logic [31:0] cw;
            cw = {4'(k + 3), 4'(7 - k), 19'h0, 3'(k), 1'b0, 1'(k & 1)};
            wr_word(0, cw);
            #1;
            check(xlat_win_start == win_tab[k], "R3 window code", xlat_win_start, win_tab[k]);
            check(xlat_enable == cw[0], "R4 enable", 32'(xlat_enable), 32'(cw[0]));
            rd_word(0, rv);
            check(rv == cw, "R4 ctrl readback", rv, cw);
        end
        wr_word(0, 32'h0000_0009); // code 2, enabled
        wr_word(1, 32'h0ABC_DEF0);
        #1;
        check(xlat_tbl_base == 32'h0ABC_DEF0, "R4 table base out", xlat_tbl_base, 32'h0ABC_DEF0);
        check(xlat_win_start == 32'hFC00_0000, "R5 hold after table write", xlat_win_start, 32'hFC00_0000);

        // R2 / R6: distinct pattern into every storage word
        for (int w = 1024; w <= 2048; w++) begin
            if (is_store(w)) wr_word(w, (32'(w) * 32'h0101_0101) ^ 32'hDEAD_BEE7);
        end
        rd_word(2048, rv);
        exp = {((32'(2048) * 32'h0101_0101) ^ 32'hDEAD_BEE7) >> 4, 4'h8};
        check(rv == exp, "R6 mid nibble", rv, exp);
        check(xlat_win_start == 32'hFC00_0000, "R5 hold after storage writes", xlat_win_start, 32'hFC00_0000);

        // R7 flush pulses
        wr_word(5, 32'h1111_2222);
        #1;
        check(tlb_flush_pulse == 1'b1, "R7 tlb pulse high", 32'(tlb_flush_pulse), 1);
        check(page_flush_pulse == 1'b0, "R7 page pulse idle", 32'(page_flush_pulse), 0);
        @(negedge clk); #1;
        check(tlb_flush_pulse == 1'b0, "R7 tlb pulse one cycle", 32'(tlb_flush_pulse), 0);
        wr_word(6, 32'hCAFE_F00D);
        #1;
        check(page_flush_pulse == 1'b1, "R7 page pulse high", 32'(page_flush_pulse), 1);
        check(page_flush_addr == 32'hCAFE_F00D, "R7 page data", page_flush_addr, 32'hCAFE_F00D);
        check(tlb_flush_pulse == 1'b0, "R7 tlb idle on page", 32'(tlb_flush_pulse), 0);
        @(negedge clk); #1;
        check(page_flush_pulse == 1'b0, "R7 page pulse one cycle", 32'(page_flush_pulse), 0);

        // R9: write every unmapped word and out-of-range addresses
        win_before = xlat_win_start;
        en_before = xlat_enable;
        for (int w = 0; w < NW + 1024; w++) begin
            if (!is_store(w) && w != 5 && w != 6) wr_word(w, ~(32'(w) * 32'h0001_0003));
        end
        wr_addr(BASE - 4, 32'hFFFF_FFFF);
        wr_addr(BASE + 32'h0001_0000, 32'hFFFF_FFFF);
        #1;
        check(xlat_win_start == win_before, "R9 window untouched", xlat_win_start, win_before);
        check(xlat_enable == en_before, "R9 enable untouched", 32'(xlat_enable), 32'(en_before));
        check(xlat_tbl_base == 32'h0ABC_DEF0, "R9 table base untouched", xlat_tbl_base, 32'h0ABC_DEF0);

        // R2 / R8 / R9: exhaustive read sweep
        for (int w = 0; w < NW; w++) begin
            rd_word(w, rv);
            if (is_store(w)) check(rv == model[w], "R2 storage readback", rv, model[w]);
            else             check(rv == 0, "R8 zero read", rv, 0);
        end
        rd_word(-1, rv);
        check(rv == 0, "R8 below base", rv, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule